// File: doc/BRIEF.md
# Split Instruction/Data Address Translator

This block maps 16-bit virtual addresses to 22-bit physical addresses for a processor with three privilege levels: kernel, supervisor and user. Each level owns sixteen mapping slots. Eight slots serve instruction references and eight serve operand references. A slot is a pair of registers: a base register, which gives the page frame, and a descriptor register, whose access-control field marks the page as absent, read-only or read/write. A per-level enable in the second control register decides whether operand references use the data slots. When that enable is clear, operand references use the instruction slots.

Software reaches every slot and both control registers through a simple word-wide register bus. Writes take effect at the clock edge. Read data is combinational from the address. Translation requests enter on a valid/ready stream and leave one cycle later on a second valid/ready stream. A response is held while `rsp_ready` is low, and no new request is taken until it leaves. A request can be rejected. The block then flags an abort, and the first control register captures the page, space and privilege level of the failing reference. That capture is frozen until software writes the register.

Top module: `split_xlate`

## Requirements
- R1: Each mapping register sits in a 64-byte window whose base is octal 17772300 for kernel, 17772200 for supervisor and 17777600 for user. Within the window, address bit 5 selects the base register (1) or the descriptor (0), bit 4 selects the data set (1) or the instruction set (0), and bits 3:1 give the page. A written word reads back unchanged on `reg_rdata` with `reg_hit` high. Any other address reads 0 with `reg_hit` low, and a write to it changes nothing.
- R2: The second control register is at octal 17772516. Bits 5:0 are read/write and bits 15:6 read as 0. Bit 2 enables the data set for kernel, bit 1 for supervisor and bit 0 for user.
- R3: After `rst_n` every register reads 0 and no response is pending. A one-cycle `init` pulse clears the second control register, and it wins over a write to that register in the same cycle.
- R4: Instruction references (`req_dspace`=0) always use the instruction set. Operand references use the data set only when the level's enable bit is set, and use the instruction set otherwise.
- R5: With relocation on, the page is `req_va[15:13]`. `rsp_pa` = (base register << 6) + `req_va[12:0]`, modulo 2^22.
- R6: With relocation off (first control register bit 0 = 0), `rsp_pa` is `req_va` zero-extended, there is no abort, and the abort status is left unchanged.
- R7: With relocation on, level code 10 is illegal. The reference aborts with status bit 15 set and the captured level equal to 10.
- R8: Descriptor bits 2:1 form the access field. Codes 00 and 10 abort with status bit 13 set. Code 01 aborts writes with bit 15 set and lets reads through. Code 11 allows everything. An aborted response carries `rsp_pa` = 0.
- R9: The first abort while status bits 15:13 are all 0 records the flags in 15:13, the level in 6:5, the space in bit 4 (1 only when the data set was used) and the page in 3:1. Later aborts leave the register unchanged.
- R10: The first control register is at octal 17777572. A write loads bits 15:13, 6:1 and 0 from the write data, and takes priority over a capture in the same cycle. Bits 12:7 read as 0.
- R11: `req_ready` is high when no response is pending or `rsp_ready` is high. A request accepted at an edge shows on `rsp_valid` after that edge. A stalled response keeps `rsp_pa` and `rsp_abort` stable.
- R12: A translation uses register contents from before any bus write at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Bus initialise pulse; clears the data-set enables |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 22 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| reg_hit | output | 1 | `reg_addr` selects a register of this block |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be taken |
| req_va | input | 16 | Virtual address |
| req_mode | input | 2 | Privilege level: 00 kernel, 01 supervisor, 11 user, 10 illegal |
| req_dspace | input | 1 | 1 for operand reference, 0 for instruction fetch |
| req_write | input | 1 | Reference is a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_pa | output | 22 | Physical address (0 when aborted) |
| rsp_abort | output | 1 | Reference aborted |

## Verification
The bench uses the default parameters: 16-bit virtual addresses, 22-bit physical addresses, eight pages per set and a six-bit base shift. With these values all 48 mapping slots and every combination of the three enable bits can be swept. A base register of all ones is loaded together with a large offset, so the sum wraps past 2^22. Stalls of the response stream, overlapping bus writes and repeated aborts are also run against the reference model cycle by cycle.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  localparam int NMODES  = 3;
  localparam int NSPACES = 2;
  localparam int NSETS   = NMODES * NSPACES;
  localparam int SET_W   = $clog2(NSETS);
  localparam int SLOT_W  = SET_W - 1;
  localparam int FLAG_W  = 3;
  localparam int ENA_W   = 6;

  typedef enum logic [1:0] {
    LVL_KERN = 2'b00,
    LVL_SUPV = 2'b01,
    LVL_BAD  = 2'b10,
    LVL_USER = 2'b11
  } level_e;

  typedef enum logic [1:0] {
    ACC_ABSENT = 2'b00,
    ACC_RDONLY = 2'b01,
    ACC_RSVD   = 2'b10,
    ACC_RDWR   = 2'b11
  } access_e;

  // kernel 0, supervisor 1, user 2; illegal folds onto 0 and is flagged elsewhere
  function automatic logic [SLOT_W-1:0] level_slot(input logic [1:0] lvl);
    case (lvl)
      LVL_SUPV: level_slot = SLOT_W'(1);
      LVL_USER: level_slot = SLOT_W'(2);
      default:  level_slot = SLOT_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/mmu_bus_decode.sv
module mmu_bus_decode
  import mmu_pkg::*;
#(
  parameter int AW = 22,
  parameter int PAGE_W = 3,
  parameter logic [AW-1:0] KERN_BASE = 22'o17772300,
  parameter logic [AW-1:0] SUPV_BASE = 22'o17772200,
  parameter logic [AW-1:0] USER_BASE = 22'o17777600,
  parameter logic [AW-1:0] CTL0_ADDR = 22'o17777572,
  parameter logic [AW-1:0] CTL3_ADDR = 22'o17772516
) (
  input  logic [AW-1:0]     addr,
  output logic              pg_hit,
  output logic [SET_W-1:0]  pg_set,
  output logic [PAGE_W-1:0] pg_idx,
  output logic              pg_is_base,
  output logic              ctl0_hit,
  output logic              ctl3_hit
);

  localparam int WIN_W = PAGE_W + 3;

  logic [NMODES-1:0] win_match;
  logic [SLOT_W-1:0] slot;

  for (genvar m = 0; m < NMODES; m++) begin : g_win
    localparam logic [AW-1:0] BASE = (m == 0) ? KERN_BASE :
                                     (m == 1) ? SUPV_BASE : USER_BASE;
    assign win_match[m] = (addr[AW-1:WIN_W] == BASE[AW-1:WIN_W]);
  end

  always_comb begin
    slot = '0;
    for (int m = 0; m < NMODES; m++) begin
      if (win_match[m]) slot = SLOT_W'(m);
    end
  end

  assign pg_hit     = |win_match;
  assign pg_is_base = addr[PAGE_W+2];
  assign pg_set     = {slot, addr[PAGE_W+1]};
  assign pg_idx     = addr[PAGE_W:1];
  assign ctl0_hit   = (addr[AW-1:1] == CTL0_ADDR[AW-1:1]);
  assign ctl3_hit   = (addr[AW-1:1] == CTL3_ADDR[AW-1:1]);

endmodule

// File: rtl/mmu_pagefile.sv
module mmu_pagefile
  import mmu_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              wr_base,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic              rd_base,
  output logic [REG_W-1:0]  rd_data,
  input  logic [SET_W-1:0]  xl_set,
  input  logic [PAGE_W-1:0] xl_page,
  output logic [REG_W-1:0]  xl_base,
  output logic [REG_W-1:0]  xl_desc
);

  localparam int NPG   = 1 << PAGE_W;
  localparam int NSLOT = 1 << SET_W;
  localparam int NENT  = NSLOT * NPG;

  logic [NENT-1:0][REG_W-1:0] base_flat;
  logic [NENT-1:0][REG_W-1:0] desc_flat;

  for (genvar s = 0; s < NSLOT; s++) begin : g_set
    for (genvar p = 0; p < NPG; p++) begin : g_pg
      if (s < NSETS) begin : g_reg
        logic [REG_W-1:0] base_r, desc_r;
        logic hit;
        assign hit = wr_en && (wr_set == SET_W'(s)) && (wr_page == PAGE_W'(p));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            base_r <= '0;
            desc_r <= '0;
          end else if (hit) begin
            if (wr_base) base_r <= wr_data;
            else         desc_r <= wr_data;
          end
        end
        assign base_flat[s*NPG+p] = base_r;
        assign desc_flat[s*NPG+p] = desc_r;
      end else begin : g_nil
        assign base_flat[s*NPG+p] = '0;
        assign desc_flat[s*NPG+p] = '0;
      end
    end
  end

  assign rd_data = rd_base ? base_flat[{rd_set, rd_page}] : desc_flat[{rd_set, rd_page}];
  assign xl_base = base_flat[{xl_set, xl_page}];
  assign xl_desc = desc_flat[{xl_set, xl_page}];

endmodule

// File: rtl/mmu_status.sv
module mmu_status
  import mmu_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              wr_ctl0,
  input  logic              wr_ctl3,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              cap_en,
  input  logic [FLAG_W-1:0] cap_flags,
  input  logic [1:0]        cap_level,
  input  logic              cap_dsp,
  input  logic [PAGE_W-1:0] cap_page,
  output logic [REG_W-1:0]  ctl0_rd,
  output logic [REG_W-1:0]  ctl3_rd,
  output logic              reloc_on,
  output logic [NMODES-1:0] dsp_en
);

  localparam int GAP0_W = REG_W - FLAG_W - 4 - PAGE_W;
  localparam int LVL_HI = PAGE_W + 3;

  logic [FLAG_W-1:0] flags_q;
  logic [1:0]        level_q;
  logic              dsp_q;
  logic [PAGE_W-1:0] page_q;
  logic              reloc_q;
  logic [ENA_W-1:0]  ena_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      level_q <= '0;
      dsp_q   <= 1'b0;
      page_q  <= '0;
      reloc_q <= 1'b0;
    end else if (wr_ctl0) begin
      flags_q <= wr_data[REG_W-1 -: FLAG_W];
      level_q <= wr_data[LVL_HI -: 2];
      dsp_q   <= wr_data[PAGE_W+1];
      page_q  <= wr_data[PAGE_W:1];
      reloc_q <= wr_data[0];
    end else if (cap_en && (flags_q == '0)) begin
      flags_q <= cap_flags;
      level_q <= cap_level;
      dsp_q   <= cap_dsp;
      page_q  <= cap_page;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ena_q <= '0;
    else if (init)    ena_q <= '0;
    else if (wr_ctl3) ena_q <= wr_data[ENA_W-1:0];
  end

  assign ctl0_rd  = {flags_q, {GAP0_W{1'b0}}, level_q, dsp_q, page_q, reloc_q};
  assign ctl3_rd  = {{(REG_W-ENA_W){1'b0}}, ena_q};
  assign reloc_on = reloc_q;

  // slot order kernel, supervisor, user maps onto enable bits 2, 1, 0
  for (genvar m = 0; m < NMODES; m++) begin : g_ena
    assign dsp_en[m] = ena_q[NMODES-1-m];
  end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int VA_W = 16,
  parameter int PA_W = 22,
  parameter int REG_W = 16,
  parameter int PAGE_W = 3,
  parameter int BASE_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_mode,
  input  logic              req_dspace,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_abort,
  input  logic              reloc_on,
  input  logic [NMODES-1:0] dsp_en,
  output logic [SET_W-1:0]  xl_set,
  output logic [PAGE_W-1:0] xl_page,
  input  logic [REG_W-1:0]  xl_base,
  input  logic [REG_W-1:0]  xl_desc,
  output logic              evt_abort,
  output logic [FLAG_W-1:0] evt_flags,
  output logic [1:0]        evt_level,
  output logic              evt_dsp,
  output logic [PAGE_W-1:0] evt_page
);

  localparam int OFFS_W = VA_W - PAGE_W;

  logic [SLOT_W-1:0] slot;
  logic              illegal, use_d, accept;
  access_e           acc;
  logic [FLAG_W-1:0] flags;
  logic [PA_W-1:0]   mapped, pa_next;

  assign illegal = (req_mode == LVL_BAD);
  assign slot    = level_slot(req_mode);
  assign use_d   = req_dspace && !illegal && dsp_en[slot];
  assign xl_set  = {slot, use_d};
  assign xl_page = req_va[VA_W-1 -: PAGE_W];
  assign acc     = access_e'(xl_desc[2:1]);
  assign mapped  = (PA_W'(xl_base) << BASE_SHIFT) + PA_W'(req_va[OFFS_W-1:0]);

  // flags ordered {read-only/illegal, length, non-resident}
  always_comb begin
    flags = '0;
    if (illegal) begin
      flags = 3'b100;
    end else begin
      case (acc)
        ACC_ABSENT, ACC_RSVD: flags = 3'b001;
        ACC_RDONLY:           flags = req_write ? 3'b100 : 3'b000;
        default:              flags = 3'b000;
      endcase
    end
  end

  assign pa_next   = !reloc_on ? PA_W'(req_va) : ((flags != '0) ? '0 : mapped);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign evt_abort = accept && reloc_on && (flags != '0);
  assign evt_flags = flags;
  assign evt_level = req_mode;
  assign evt_dsp   = use_d;
  assign evt_page  = xl_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_abort <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_pa    <= pa_next;
      rsp_abort <= reloc_on && (flags != '0);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/split_xlate.sv
module split_xlate
  import mmu_pkg::*;
#(
  parameter int VA_W = 16,
  parameter int PA_W = 22,
  parameter int REG_W = 16,
  parameter int AW = 22,
  parameter int PAGE_W = 3,
  parameter int BASE_SHIFT = 6,
  parameter logic [AW-1:0] KERN_BASE = 22'o17772300,
  parameter logic [AW-1:0] SUPV_BASE = 22'o17772200,
  parameter logic [AW-1:0] USER_BASE = 22'o17777600,
  parameter logic [AW-1:0] CTL0_ADDR = 22'o17777572,
  parameter logic [AW-1:0] CTL3_ADDR = 22'o17772516
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reg_hit,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_mode,
  input  logic             req_dspace,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_abort
);

  logic              pg_hit, pg_is_base, ctl0_hit, ctl3_hit;
  logic [SET_W-1:0]  pg_set, xl_set;
  logic [PAGE_W-1:0] pg_idx, xl_page;
  logic [REG_W-1:0]  pg_rd, xl_base, xl_desc, ctl0_rd, ctl3_rd;
  logic              reloc_on, ctl0_wr, ctl3_wr;
  logic [NMODES-1:0] dsp_en;
  logic              evt_abort, evt_dsp;
  logic [FLAG_W-1:0] evt_flags;
  logic [1:0]        evt_level;
  logic [PAGE_W-1:0] evt_page;

  mmu_bus_decode #(
    .AW(AW), .PAGE_W(PAGE_W), .KERN_BASE(KERN_BASE), .SUPV_BASE(SUPV_BASE),
    .USER_BASE(USER_BASE), .CTL0_ADDR(CTL0_ADDR), .CTL3_ADDR(CTL3_ADDR)
  ) u_dec (
    .addr(reg_addr), .pg_hit(pg_hit), .pg_set(pg_set), .pg_idx(pg_idx),
    .pg_is_base(pg_is_base), .ctl0_hit(ctl0_hit), .ctl3_hit(ctl3_hit)
  );

  mmu_pagefile #(.REG_W(REG_W), .PAGE_W(PAGE_W)) u_pf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr && pg_hit), .wr_set(pg_set), .wr_page(pg_idx),
    .wr_base(pg_is_base), .wr_data(reg_wdata),
    .rd_set(pg_set), .rd_page(pg_idx), .rd_base(pg_is_base), .rd_data(pg_rd),
    .xl_set(xl_set), .xl_page(xl_page), .xl_base(xl_base), .xl_desc(xl_desc)
  );

  assign ctl0_wr = reg_wr && ctl0_hit;
  assign ctl3_wr = reg_wr && ctl3_hit;

  mmu_status #(.REG_W(REG_W), .PAGE_W(PAGE_W)) u_st (
    .clk(clk), .rst_n(rst_n), .init(init),
    .wr_ctl0(ctl0_wr), .wr_ctl3(ctl3_wr), .wr_data(reg_wdata),
    .cap_en(evt_abort), .cap_flags(evt_flags), .cap_level(evt_level),
    .cap_dsp(evt_dsp), .cap_page(evt_page),
    .ctl0_rd(ctl0_rd), .ctl3_rd(ctl3_rd), .reloc_on(reloc_on), .dsp_en(dsp_en)
  );

  mmu_xlate #(
    .VA_W(VA_W), .PA_W(PA_W), .REG_W(REG_W), .PAGE_W(PAGE_W), .BASE_SHIFT(BASE_SHIFT)
  ) u_xl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_mode(req_mode), .req_dspace(req_dspace), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_abort(rsp_abort),
    .reloc_on(reloc_on), .dsp_en(dsp_en),
    .xl_set(xl_set), .xl_page(xl_page), .xl_base(xl_base), .xl_desc(xl_desc),
    .evt_abort(evt_abort), .evt_flags(evt_flags), .evt_level(evt_level),
    .evt_dsp(evt_dsp), .evt_page(evt_page)
  );

  assign reg_hit   = pg_hit || ctl0_hit || ctl3_hit;
  assign reg_rdata = pg_hit   ? pg_rd   :
                     ctl0_hit ? ctl0_rd :
                     ctl3_hit ? ctl3_rd : '0;

endmodule

// File: rtl/split_xlate_chk.sv
module split_xlate_chk #(
  parameter int VA_W = 16,
  parameter int PA_W = 22,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_va,
  input logic [1:0]       req_mode,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             rsp_abort,
  input logic             ctl0_wr,
  input logic [REG_W-1:0] ctl0_rd,
  input logic [REG_W-1:0] ctl3_rd,
  input logic             reloc_on
);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_abort)));

  // R3
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (ctl3_rd == '0));

  // R9
  status_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl0_rd[REG_W-1 -: 3] != 3'b000) && !ctl0_wr) |=> $stable(ctl0_rd[REG_W-1:1]));

  // R7
  bad_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && reloc_on && (req_mode == 2'b10)) |=> rsp_abort);

  // R6
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !reloc_on) |=>
      (!rsp_abort && (rsp_pa == PA_W'($past(req_va)))));

endmodule

bind split_xlate split_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init),
  .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_mode(req_mode),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_abort(rsp_abort),
  .ctl0_wr(ctl0_wr), .ctl0_rd(ctl0_rd), .ctl3_rd(ctl3_rd), .reloc_on(reloc_on)
);

// File: tb/split_xlate_tb.sv
module split_xlate_tb;

  localparam logic [21:0] CTL0 = 22'o17777572;
  localparam logic [21:0] CTL3 = 22'o17772516;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        reg_wr = 1'b0;
  logic [21:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_hit;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_va = '0;
  logic [1:0]  req_mode = '0;
  logic        req_dspace = 1'b0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [21:0] rsp_pa;
  logic        rsp_abort;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R3";

  always #4 clk = ~clk;

  split_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .init(init), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_hit(reg_hit),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_mode(req_mode),
    .req_dspace(req_dspace), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_abort(rsp_abort)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_base [6][8];
  logic [15:0] m_desc [6][8];
  logic [2:0]  m_flags;
  logic [1:0]  m_lvl;
  logic        m_sp;
  logic [2:0]  m_page;
  logic        m_reloc;
  logic [5:0]  m_ena;
  logic        m_rv;
  logic [21:0] m_pa;
  logic        m_ab;

  function automatic logic [21:0] win_base(input int slot);
    case (slot)
      0: return 22'o17772300;
      1: return 22'o17772200;
      default: return 22'o17777600;
    endcase
  endfunction

  function automatic logic [21:0] pg_addr(input int slot, input bit d, input bit b, input int p);
    return win_base(slot) + (b ? 22'd32 : 22'd0) + (d ? 22'd16 : 22'd0) + 22'(p * 2);
  endfunction

  // returns -1 when the address is not a mapping register, else slot*100+d*10+b, page via out
  function automatic int find_pg(input logic [21:0] a, output int p);
    p = 0;
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int b = 0; b < 2; b++) begin
          for (int q = 0; q < 8; q++) begin
            if (a[21:1] == pg_addr(s, d[0], b[0], q) >> 1) begin
              p = q;
              return s * 100 + d * 10 + b;
            end
          end
        end
      end
    end
    return -1;
  endfunction

  function automatic logic [15:0] ctl0_val();
    return {m_flags, 6'b0, m_lvl, m_sp, m_page, m_reloc};
  endfunction

  function automatic void exp_read(output logic hit, output logic [15:0] d);
    int p, code;
    code = find_pg(reg_addr, p);
    hit = 1'b1;
    if (code >= 0) begin
      if (code % 10 == 1) d = m_base[(code / 100) * 2 + (code / 10) % 10][p];
      else                d = m_desc[(code / 100) * 2 + (code / 10) % 10][p];
    end else if (reg_addr[21:1] == CTL0[21:1]) d = ctl0_val();
    else if (reg_addr[21:1] == CTL3[21:1])     d = {10'b0, m_ena};
    else begin
      hit = 1'b0;
      d = '0;
    end
  endfunction

  function automatic void model_xl(output logic ab, output logic [21:0] pa,
                                   output logic [2:0] fl, output logic sp);
    int slot, set;
    logic [1:0] acf;
    logic [15:0] b;
    ab = 0; fl = 0; sp = 0; pa = 22'(req_va);
    if (!m_reloc) return;
    if (req_mode == 2'b10) begin
      ab = 1; fl = 3'b100; pa = '0;
      return;
    end
    slot = (req_mode == 2'b00) ? 0 : (req_mode == 2'b01) ? 1 : 2;
    sp = req_dspace && m_ena[2 - slot];
    set = slot * 2 + int'(sp);
    acf = m_desc[set][req_va[15:13]][2:1];
    b = m_base[set][req_va[15:13]];
    if (acf == 2'b00 || acf == 2'b10) fl = 3'b001;
    else if (acf == 2'b01 && req_write) fl = 3'b100;
    ab = (fl != 0);
    pa = ab ? 22'd0 : 22'((32'(b) * 64 + 32'(req_va[12:0])) % (1 << 22));
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic acc, t_ab, t_sp, w0;
    logic [21:0] t_pa;
    logic [2:0] t_fl;
    int p, code;
    if (!rst_n) begin
      for (int s = 0; s < 6; s++) for (int q = 0; q < 8; q++) begin
        m_base[s][q] = '0; m_desc[s][q] = '0;
      end
      m_flags = 0; m_lvl = 0; m_sp = 0; m_page = 0; m_reloc = 0; m_ena = 0;
      m_rv = 0; m_pa = 0; m_ab = 0;
    end else begin
      model_xl(t_ab, t_pa, t_fl, t_sp);
      acc = req_valid && (!m_rv || rsp_ready);
      w0 = reg_wr && (reg_addr[21:1] == CTL0[21:1]);
      if (acc) begin
        m_rv = 1; m_pa = t_pa; m_ab = t_ab;
        if (t_ab && m_flags == 0 && !w0) begin
          m_flags = t_fl; m_lvl = req_mode; m_sp = t_sp; m_page = req_va[15:13];
        end
      end else if (rsp_ready) m_rv = 0;
      if (reg_wr) begin
        code = find_pg(reg_addr, p);
        if (code >= 0) begin
          if (code % 10 == 1) m_base[(code / 100) * 2 + (code / 10) % 10][p] = reg_wdata;
          else                m_desc[(code / 100) * 2 + (code / 10) % 10][p] = reg_wdata;
        end
        if (w0) begin
          m_flags = reg_wdata[15:13]; m_lvl = reg_wdata[6:5]; m_sp = reg_wdata[4];
          m_page = reg_wdata[3:1]; m_reloc = reg_wdata[0];
        end
        if (reg_addr[21:1] == CTL3[21:1]) m_ena = reg_wdata[5:0];
      end
      if (init) m_ena = 0;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin : cmp
    logic eh;
    logic [15:0] ed;
    #2;
    if (!done) begin
      exp_read(eh, ed);
      chk("R11", "req_ready", 32'(req_ready), 32'(!m_rv || rsp_ready));
      chk("R11", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) begin
        chk(cur_req, "rsp_pa", 32'(rsp_pa), 32'(m_pa));
        chk(cur_req, "rsp_abort", 32'(rsp_abort), 32'(m_ab));
      end
      chk(cur_req, "reg_hit", 32'(reg_hit), 32'(eh));
      chk(cur_req, "reg_rdata", 32'(reg_rdata), 32'(ed));
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_wr(input logic [21:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic bus_rd(input logic [21:0] a);
    reg_addr = a;
    @(negedge clk);
  endtask

  task automatic xreq(input logic [15:0] va, input logic [1:0] md, input bit ds, input bit wr);
    req_valid = 1; req_va = va; req_mode = md; req_dspace = ds; req_write = wr;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin : wdog
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [1:0] lv [3];
    lv[0] = 2'b00; lv[1] = 2'b01; lv[2] = 2'b11;
    // R3: reset state
    cur_req = "R3";
    reg_addr = CTL0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    bus_rd(CTL3);
    bus_rd(pg_addr(2, 1, 1, 7));

    // R1: fill all 48 pairs, read back, unmapped address
    cur_req = "R1";
    for (int s = 0; s < 3; s++) for (int d = 0; d < 2; d++) for (int q = 0; q < 8; q++) begin
      bus_wr(pg_addr(s, d[0], 1, q), 16'($urandom));
      bus_wr(pg_addr(s, d[0], 0, q), 16'(((s * 16 + d * 8 + q) << 8) | 6));
    end
    for (int s = 0; s < 3; s++) for (int q = 0; q < 8; q += 3) begin
      bus_rd(pg_addr(s, 0, 1, q));
      bus_rd(pg_addr(s, 1, 0, q));
    end
    bus_wr(22'o17772400, 16'h1234);
    bus_rd(22'o17772400);
    bus_rd(22'o17772276 + 22'd2);

    // R2: control register 3 field widths
    cur_req = "R2";
    bus_wr(CTL3, 16'hFFFF);
    bus_rd(CTL3);

    // R3: init alone and against a same-cycle write
    cur_req = "R3";
    init = 1; @(negedge clk); init = 0;
    bus_rd(CTL3);
    bus_wr(CTL3, 16'h0005);
    init = 1; bus_wr(CTL3, 16'h0007); init = 0;
    bus_rd(CTL3);

    // R6: relocation off passes the address through
    cur_req = "R6";
    for (int i = 0; i < 12; i++) xreq(16'($urandom), 2'(i % 4), i[0], i[1]);

    // R10: turn relocation on, check bits 12:7 stay zero
    cur_req = "R10";
    bus_wr(CTL0, 16'h1F81);
    bus_rd(CTL0);
    bus_wr(CTL0, 16'h0001);

    // R4: every enable combination, every level, both reference kinds
    cur_req = "R4";
    for (int e = 0; e < 8; e++) begin
      bus_wr(CTL3, 16'(e));
      for (int m = 0; m < 3; m++) begin
        xreq(16'($urandom), lv[m], 0, 0);
        xreq(16'($urandom), lv[m], 1, 0);
      end
    end

    // R5: arithmetic including wrap past 2^22
    cur_req = "R5";
    bus_wr(pg_addr(0, 0, 1, 7), 16'hFFFF);
    xreq(16'hFFFF, 2'b00, 0, 0);
    xreq(16'hE000, 2'b00, 0, 1);
    for (int i = 0; i < 40; i++) xreq(16'($urandom), lv[i % 3], i[0], i[1]);

    // R11: response stall
    cur_req = "R11";
    rsp_ready = 0;
    xreq(16'h1234, 2'b11, 0, 0);
    xreq(16'h4321, 2'b01, 1, 0);
    req_valid = 1; repeat (3) @(negedge clk); req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);

    // R8 / R9 / R10: aborts and status capture
    cur_req = "R8";
    bus_wr(CTL3, 16'h0004);
    bus_wr(pg_addr(0, 1, 0, 2), 16'h0000);
    xreq(16'h4abc, 2'b00, 1, 0);
    cur_req = "R9";
    bus_rd(CTL0);
    bus_wr(pg_addr(2, 0, 0, 5), 16'h0002);
    xreq(16'hA000, 2'b11, 0, 1);
    bus_rd(CTL0);
    cur_req = "R10";
    bus_wr(CTL0, 16'h0001);
    bus_rd(CTL0);
    cur_req = "R8";
    xreq(16'hA010, 2'b11, 0, 0);
    xreq(16'hA020, 2'b11, 0, 1);
    bus_rd(CTL0);
    bus_wr(CTL0, 16'h0001);
    bus_wr(pg_addr(1, 0, 0, 1), 16'h0004);
    xreq(16'h2000, 2'b01, 0, 0);
    bus_rd(CTL0);
    bus_wr(CTL0, 16'h0001);

    // R7: illegal level
    cur_req = "R7";
    xreq(16'h6000, 2'b10, 1, 0);
    bus_rd(CTL0);
    // R10: software write wins over a same-cycle capture
    cur_req = "R10";
    req_valid = 1; req_va = 16'h6000; req_mode = 2'b10;
    bus_wr(CTL0, 16'h0001);
    req_valid = 0;
    bus_rd(CTL0);

    // R12: translation against a same-cycle base write
    cur_req = "R12";
    req_valid = 1; req_va = 16'h2222; req_mode = 2'b00; req_dspace = 0; req_write = 0;
    bus_wr(pg_addr(0, 0, 1, 1), 16'h0ABC);
    req_valid = 0;
    xreq(16'h2222, 2'b00, 0, 0);

    // R5: random mix of bus traffic, requests and stalls
    cur_req = "R5";
    for (int i = 0; i < 2500; i++) begin
      int k;
      k = int'($urandom % 16);
      rsp_ready = ($urandom % 4) != 0;
      req_valid = ($urandom % 2) == 1;
      req_va = 16'($urandom); req_mode = 2'($urandom); req_dspace = 1'($urandom);
      req_write = 1'($urandom);
      init = (k == 15);
      if (k < 4) begin
        reg_wr = 1;
        reg_addr = pg_addr(int'($urandom % 3), 1'($urandom), 1'($urandom), int'($urandom % 8));
        reg_wdata = 16'($urandom);
      end else if (k == 4) begin
        reg_wr = 1; reg_addr = CTL0; reg_wdata = 16'($urandom) | 16'h0001;
      end else if (k == 5) begin
        reg_wr = 1; reg_addr = CTL3; reg_wdata = 16'($urandom);
      end else begin
        reg_wr = 0;
        reg_addr = (k < 10) ? CTL0 : pg_addr(int'($urandom % 3), 1'($urandom), 1'($urandom), int'($urandom % 8));
      end
      @(negedge clk);
    end
    reg_wr = 0; req_valid = 0; init = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule